// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block caches virtual-to-physical page translations in a fully associative array. Any slot can hold a translation of any of three page sizes: 4 KB, 2 MB or 1 GB. The requester presents a 48-bit virtual address. One cycle later the block returns a response: the hit flag, the 48-bit physical address and the page-size code of the matching slot. Each slot keeps a size code, and that code decides how many page-number bits take part in the compare. The remaining low address bits pass straight through as the offset.

On a miss, the lookup port stops accepting requests. The block raises a walk request that carries the missing page number and holds it until an external walker supplies a refill. The refill goes into a slot that already matches its page number if there is one. If not, it goes into the lowest free slot. If no slot is free, it goes into the slot chosen by a binary-tree pseudo-LRU. A flush pulse clears every slot, for example when the address-space root changes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is invalid, `lk_ready` is 1, `walk_req` is 0 and `rsp_valid` is 0.
- R2: A lookup is taken when `lk_valid` and `lk_ready` are both 1. Its response appears with `rsp_valid`=1 on the next cycle. A hit takes no extra cycles.
- R3: Size code 2'b00 (4 KB) compares all 36 page-number bits `va[47:12]`. The physical address is `{pfn[35:0], va[11:0]}`.
- R4: Size code 2'b01 (2 MB) compares only `va[47:21]`. The physical address is `{pfn[35:9], va[20:0]}`, so the low 9 stored frame bits are ignored.
- R5: Size codes 2'b10 and 2'b11 (1 GB) compare only `va[47:30]`. The physical address is `{pfn[35:18], va[29:0]}`. `rsp_size` returns the stored code.
- R6: A miss returns `rsp_hit`=0, `rsp_paddr`=0 and `rsp_size`=0. From the next cycle `lk_ready` is 0 and `walk_req` is 1, with `walk_vpn`=`va[47:12]` of the missing lookup.
- R7: `fill_valid` installs `{fill_vpn, fill_pfn, fill_size}`. If a miss is pending, `walk_req` drops and `lk_ready` returns to 1 on the next cycle.
- R8: When several valid slots match a lookup, the lowest-indexed slot supplies the result.
- R9: A refill whose page number hits a valid slot (under that slot's size) overwrites the lowest such slot instead of adding a duplicate.
- R10: With no matching slot, a refill takes the lowest invalid slot. If all slots are valid, it takes the pseudo-LRU victim. The tree has one pointer bit per internal node (0 = left). Every hit or refill turns the pointers on its path away from the touched slot, and the victim is found by following the pointers from the root. Filling all 64 slots in index order makes slot 0 the victim. Touching slot 0 after that makes slot 32 the victim.
- R11: `flush` invalidates every slot, so later lookups miss. A refill in the same cycle as a flush is dropped, although it still ends a pending miss.
- R12: While `lk_ready` is 0, `lk_valid` is ignored: no response is produced and `walk_vpn` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_ready | output | 1 | Lookup port can accept |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 48 | Translated physical address |
| rsp_size | output | 2 | Size code of the hitting slot |
| walk_req | output | 1 | Page walk requested |
| walk_vpn | output | 36 | Page number to walk |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | 36 | Refill page number |
| fill_pfn | input | 36 | Refill frame number |
| fill_size | input | 2 | Refill size code |

## Verification
Every lookup result is registered once. Hit, address and size are therefore due exactly one clock after the accepting edge. The stall state and `walk_vpn` of a miss appear at that same edge, and a refill frees the port one edge after its strobe. The bench drives inputs on falling edges. It samples one falling edge after each strobe, which is the first half-cycle in which the result can be present, and it never samples the cycle of the strobe itself. Ignored requests during a stall are checked at that same sampling point, where a wrongly accepted request would already show `rsp_valid`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 48;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = 48;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int LVL_W = 9;

  typedef enum logic [1:0] {
    PG_4K  = 2'b00,
    PG_2M  = 2'b01,
    PG_1G  = 2'b10,
    PG_1GX = 2'b11
  } pg_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    pg_e              size;
  } tlb_ent_t;

  // Bits of the page number that take part in the compare for a size.
  function automatic logic [VPN_W-1:0] cmp_mask(pg_e sz);
    logic [VPN_W-1:0] m;
    case (sz)
      PG_4K:   m = '1;
      PG_2M:   m = {{(VPN_W-LVL_W){1'b1}}, {LVL_W{1'b0}}};
      default: m = {{(VPN_W-2*LVL_W){1'b1}}, {(2*LVL_W){1'b0}}};
    endcase
    return m;
  endfunction

  function automatic logic [PA_W-1:0] make_pa(logic [PFN_W-1:0] pfn,
                                              logic [VA_W-1:0] va, pg_e sz);
    logic [PA_W-1:0] pa;
    case (sz)
      PG_4K:   pa = {pfn, va[OFF_W-1:0]};
      PG_2M:   pa = {pfn[PFN_W-1:LVL_W], va[OFF_W+LVL_W-1:0]};
      default: pa = {pfn[PFN_W-1:2*LVL_W], va[OFF_W+2*LVL_W-1:0]};
    endcase
    return pa;
  endfunction
endpackage

// File: rtl/tlb_first.sv
// Lowest-index request finder.
module tlb_first #(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/tlb_plru.sv
// Binary-tree pseudo-LRU over N slots (N a power of two, N >= 2).
module tlb_plru #(
  parameter int N  = 64,
  localparam int LV = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [LV-1:0] touch_idx,
  output logic [LV-1:0] victim
);
  logic [N-2:0] tree_q, tree_d;

  always_comb begin
    logic [LV:0] nd;
    nd = (LV+1)'(1);
    for (int lv = 0; lv < LV; lv++) begin
      nd = {nd[LV-1:0], tree_q[LV'(nd - (LV+1)'(1))]};
    end
    victim = nd[LV-1:0];
  end

  always_comb begin
    logic [LV:0]   nd;
    logic [LV-1:0] path;
    tree_d = tree_q;
    nd     = (LV+1)'(1);
    path   = touch_idx;
    if (touch_en) begin
      for (int lv = 0; lv < LV; lv++) begin
        tree_d[LV'(nd - (LV+1)'(1))] = ~path[LV-1];
        nd   = {nd[LV-1:0], path[LV-1]};
        path = path << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tree_q <= '0;
    else if (touch_en) tree_q <= tree_d;
  end

  p_victim_not_recent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (victim != $past(touch_idx)));
endmodule

// File: rtl/tlb_cam.sv
// Slot storage with per-slot size-masked compare for lookup and refill.
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [IW-1:0]    rd_idx,
  output logic [N-1:0]     lk_match,
  output logic [N-1:0]     fl_match,
  output logic [N-1:0]     vld,
  output tlb_ent_t         rd_ent
);
  logic [N-1:0] vld_q, vld_d;
  tlb_ent_t     ent_q [N];
  logic         wr_go;

  assign wr_go = wr_en && !flush;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [VPN_W-1:0] m;
    assign m           = cmp_mask(ent_q[g].size);
    assign lk_match[g] = vld_q[g] && (((ent_q[g].vpn ^ lk_vpn) & m) == '0);
    assign fl_match[g] = vld_q[g] && (((ent_q[g].vpn ^ fl_vpn) & m) == '0);
  end

  always_comb begin
    vld_d = vld_q;
    if (flush)      vld_d = '0;
    else if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_go) ent_q[wr_idx] <= wr_ent;
  end

  assign vld    = vld_q;
  assign rd_ent = ent_q[rd_idx];

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
  p_fill_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_size,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [1:0]       fill_size
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  // Reset synchronizer: asserts at once, deasserts on the second edge.
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  st_e              st_q, st_d;
  logic             accept, miss;
  logic [VPN_W-1:0] lk_vpn;
  logic [ENTRIES-1:0] lk_match, fl_match, vld;
  logic             hit_any, dup_any, free_any;
  logic [IW-1:0]    hit_idx, dup_idx, free_idx, victim, wr_idx, touch_idx;
  logic             touch_en;
  tlb_ent_t         wr_ent, rd_ent;

  logic             rsp_valid_q, rsp_hit_q;
  logic [PA_W-1:0]  rsp_pa_q;
  logic [1:0]       rsp_sz_q;
  logic [VPN_W-1:0] walk_vpn_q;

  assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  assign lk_ready = (st_q == ST_IDLE);
  assign accept   = lk_valid && lk_ready;
  assign miss     = accept && !hit_any;

  tlb_cam #(.N(ENTRIES)) u_cam (
    .clk      (clk),
    .rst_n    (rst_sn),
    .flush    (flush),
    .wr_en    (fill_valid),
    .wr_idx   (wr_idx),
    .wr_ent   (wr_ent),
    .lk_vpn   (lk_vpn),
    .fl_vpn   (fill_vpn),
    .rd_idx   (hit_idx),
    .lk_match (lk_match),
    .fl_match (fl_match),
    .vld      (vld),
    .rd_ent   (rd_ent)
  );

  tlb_first #(.N(ENTRIES)) u_hit  (.req(lk_match), .any(hit_any),  .idx(hit_idx));
  tlb_first #(.N(ENTRIES)) u_dup  (.req(fl_match), .any(dup_any),  .idx(dup_idx));
  tlb_first #(.N(ENTRIES)) u_free (.req(~vld),     .any(free_any), .idx(free_idx));

  tlb_plru #(.N(ENTRIES)) u_plru (
    .clk       (clk),
    .rst_n     (rst_sn),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  always_comb begin
    wr_ent.vpn  = fill_vpn;
    wr_ent.pfn  = fill_pfn;
    wr_ent.size = pg_e'(fill_size);
    if (dup_any)       wr_idx = dup_idx;
    else if (free_any) wr_idx = free_idx;
    else               wr_idx = victim;
  end

  always_comb begin
    touch_en  = 1'b0;
    touch_idx = hit_idx;
    if (fill_valid && !flush) begin
      touch_en  = 1'b1;
      touch_idx = wr_idx;
    end else if (accept && hit_any) begin
      touch_en  = 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (miss)       st_d = ST_WAIT;
      ST_WAIT: if (fill_valid) st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q        <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_pa_q    <= '0;
      rsp_sz_q    <= '0;
      walk_vpn_q  <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= accept;
      if (accept) begin
        rsp_hit_q <= hit_any;
        rsp_pa_q  <= hit_any ? make_pa(rd_ent.pfn, lk_vaddr, rd_ent.size) : '0;
        rsp_sz_q  <= hit_any ? rd_ent.size : 2'b00;
      end
      if (miss) walk_vpn_q <= lk_vpn;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_paddr = rsp_pa_q;
  assign rsp_size  = rsp_sz_q;
  assign walk_req  = (st_q == ST_WAIT);
  assign walk_vpn  = walk_vpn_q;

  p_rsp_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    accept |=> rsp_valid);
  p_miss_stalls_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    miss |=> (!lk_ready && walk_req && walk_vpn == $past(lk_vpn)));
  p_fill_releases_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (walk_req && fill_valid) |=> (lk_ready && !walk_req));
  p_stall_holds_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    (walk_req && !fill_valid) |=> (walk_req && !rsp_valid && $stable(walk_vpn)));
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, lk_valid, fill_valid;
  logic [47:0] lk_vaddr;
  logic [35:0] fill_vpn, fill_pfn;
  logic [1:0]  fill_size;
  logic        lk_ready, rsp_valid, rsp_hit, walk_req;
  logic [47:0] rsp_paddr;
  logic [1:0]  rsp_size;
  logic [35:0] walk_vpn;

  int n_tot = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_size(rsp_size),
    .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_size(fill_size)
  );

  typedef struct packed {
    logic [47:0] va;
    logic [47:0] pa;
    logic [1:0]  sz;
  } vec_t;

  // Hits against the preloaded slots: 4K, 2M, overlap, 1G, 1G edge, 2M top, size 3.
  localparam vec_t VT [7] = '{
    '{48'h0000_1234_5ABC, 48'h0000_ABCD_EABC, 2'b00},
    '{48'h0000_4021_2345, 48'h0007_7701_2345, 2'b01},
    '{48'h0000_4020_3777, 48'h0000_5555_5777, 2'b00},
    '{48'h0000_ABCD_1234, 48'h000C_6BCD_1234, 2'b10},
    '{48'h0000_8000_0000, 48'h000C_4000_0000, 2'b10},
    '{48'h0000_403F_FFFF, 48'h0007_771F_FFFF, 2'b01},
    '{48'h0001_0000_0042, 48'h0000_8000_0042, 2'b11}
  };
  localparam string VT_TAG [7] = '{"R3", "R4", "R8", "R5", "R5", "R4", "R5"};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [47:0] va);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [35:0] pfn, input logic [1:0] sz);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn   = vpn;
    fill_pfn   = pfn;
    fill_size  = sz;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [47:0] va,
                            input logic [47:0] pa, input logic [1:0] sz);
    lookup(va);
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"}, 64'(rsp_hit), 64'd1);
    chk({tag, " paddr"}, 64'(rsp_paddr), 64'(pa));
    chk({tag, " size"}, 64'(rsp_size), 64'(sz));
  endtask

  task automatic expect_miss(input string tag, input logic [47:0] va);
    lookup(va);
    chk({tag, " miss rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " miss hit"}, 64'(rsp_hit), 64'd0);
    chk({tag, " miss stall"}, 64'({lk_ready, walk_req}), 64'b01);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
    lk_vaddr = '0; fill_vpn = '0; fill_pfn = '0; fill_size = '0;
    repeat (3) @(negedge clk);
    // R1: state while and after reset
    chk("R1 ready", 64'(lk_ready), 64'd1);
    chk("R1 walk_req", 64'(walk_req), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 walk_req after", 64'(walk_req), 64'd0);
    expect_miss("R1", 48'h0000_0000_0000);
    fill(36'h0_0000_0000, 36'h0_0000_0003, 2'b00);

    // Preload: A 4K, D 4K inside B's region (lower index), B 2M, C 1G, E size 3
    fill(36'h0_0001_2345, 36'h0_000A_BCDE, 2'b00);
    fill(36'h0_0004_0203, 36'h0_0005_5555, 2'b00);
    fill(36'h0_0004_0200, 36'h0_0077_71FF, 2'b01);
    fill(36'h0_0008_0000, 36'h0_00C4_0123, 2'b10);
    fill(36'h0_0010_0000, 36'h0_0008_0000, 2'b11);

    for (int i = 0; i < 7; i++) begin
      expect_hit(VT_TAG[i], VT[i].va, VT[i].pa, VT[i].sz);
    end

    // R2: a hit's response lasts one cycle only
    @(negedge clk);
    chk("R2 single pulse", 64'(rsp_valid), 64'd0);

    // R6 / R12 / R7: miss, stall, ignored request, refill
    expect_miss("R6", 48'h0000_2222_2333);
    chk("R6 paddr zero", 64'(rsp_paddr), 64'd0);
    chk("R6 size zero", 64'(rsp_size), 64'd0);
    chk("R6 walk_vpn", 64'(walk_vpn), 64'h2_2222);
    lookup(48'h0000_3333_3000);
    chk("R12 no response", 64'(rsp_valid), 64'd0);
    chk("R12 walk_vpn held", 64'(walk_vpn), 64'h2_2222);
    chk("R12 still waiting", 64'(walk_req), 64'd1);
    fill(36'h0_0002_2222, 36'h0_0009_9999, 2'b00);
    chk("R7 ready back", 64'({lk_ready, walk_req}), 64'b10);
    expect_hit("R7", 48'h0000_2222_2333, 48'h0000_9999_9333, 2'b00);

    // R9: refill of an existing page overwrites it
    fill(36'h0_0001_2345, 36'h0_0001_1111, 2'b00);
    expect_hit("R9", 48'h0000_1234_5ABC, 48'h0000_1111_1ABC, 2'b00);

    // R10: fill all 64 slots in order, victim 0, then victim 32
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 64; i++) begin
      fill(36'h1000 + 36'(i), 36'h2000 + 36'(i), 2'b00);
    end
    fill(36'h5000, 36'h7000, 2'b00);
    expect_hit("R10 new in slot0", 48'h0000_0500_0123, 48'h0000_0700_0123, 2'b00);
    expect_hit("R10 slot1 kept", 48'h0000_0100_1456, 48'h0000_0200_1456, 2'b00);
    fill(36'h6000, 36'h8000, 2'b00);
    expect_hit("R10 new in slot32", 48'h0000_0600_0ABC, 48'h0000_0800_0ABC, 2'b00);
    expect_hit("R10 slot33 kept", 48'h0000_0102_1000, 48'h0000_0202_1000, 2'b00);
    expect_miss("R10 slot32 evicted", 48'h0000_0102_0000);
    lookup(48'h0000_0100_0000);
    chk("R10 slot0 evicted (stalled, no rsp)", 64'(rsp_valid), 64'd0);

    // R11: flush with simultaneous refill ends the wait but drops the refill
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 36'h1020; fill_pfn = 36'h2020; fill_size = 2'b00;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    chk("R11 wait ended", 64'(lk_ready), 64'd1);
    expect_miss("R11 refill dropped", 48'h0000_0102_0000);
    fill(36'h0_0000_0777, 36'h0_0000_0777, 2'b00);
    expect_miss("R11 flushed entry", 48'h0000_0500_0123);
    fill(36'h0_0000_0778, 36'h0_0000_0778, 2'b00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tot++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end
endmodule